// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

The walker turns a chain of descriptors held in memory into a sequence of transfer requests for a DMA data mover. Software writes the address of the first descriptor, sets the hardware-descriptor enable and pulses submit. The walker then reads each 48-byte descriptor as one read burst over a dedicated read-only memory-mapped master port. It presents the unpacked addresses, lengths, strides and identifier on a valid/ready request port. It then waits for the data mover to report that the segment is complete.

After each completion the walker reads the descriptor's flags. If the final-descriptor flag is clear, it fetches the descriptor at the next-pointer address. If the flag is set, it drops back to idle. A second flag selects a one-cycle interrupt pulse when the segment finishes. An error response on any beat of a descriptor fetch ends the walk and leaves a sticky error indication until the next start. While hardware-descriptor mode is enabled, the legacy auto-repeat request is masked.

Top module: `sg_desc_walker`

## Requirements
- R1: After reset, `busy`, `err`, `irq`, `req_valid`, `m_arvalid` and `m_rready` are all low.
- R2: A walk starts only on a `cfg_submit` pulse while idle, with `cfg_hwdesc_en` high and a first-descriptor address written at least once through `cfg_addr_we`. A submit that lacks the enable or the written address is ignored: `busy` stays low and no read is issued.
- R3: Each descriptor is read as one incrementing burst: `m_araddr` is the descriptor address, `m_arlen`=5, `m_arsize`=3 and `m_arburst`=2'b01. `m_arvalid` and `m_araddr` hold until `m_arready`.
- R4: Descriptor fields are little-endian at these byte offsets: flags 0 (32 bits), id 4 (32), destination 8 (64), source 16 (64), next pointer 24 (64), y length 32 (32), x length 36 (32), source stride 40 (32), destination stride 44 (32). The request carries id, both addresses, both lengths and both strides unchanged. An x length of 0 therefore passes through as 0, which means one byte.
- R5: While `req_valid` is high and `req_ready` is low, `req_valid` and every request field stay unchanged.
- R6: After `done_in` for a descriptor whose flags bit 0 is clear, the next read is at that descriptor's next pointer. If bit 0 is set, `busy` is low in the cycle after `done_in`.
- R7: `irq` is high for exactly one cycle, the cycle after `done_in`, when the completed descriptor has flags bit 1 set. Otherwise `irq` stays low.
- R8: A non-zero `m_rresp` on any beat of a descriptor fetch stops the walk after that burst's last beat. No request is issued, `busy` falls and `err` stays high until the next accepted start clears it.
- R9: `busy` is high from the cycle after an accepted start until the walk returns to idle. A submit that arrives while busy has no effect on the walk.
- R10: `cyclic_active` equals `cfg_cyclic` AND NOT `cfg_hwdesc_en`.
- R11: `done_in` is ignored unless a request has been accepted and its completion is pending. In particular it does not cause an `irq` and does not withdraw a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr_we | input | 1 | Write strobe for the first-descriptor address |
| cfg_addr_wdata | input | ADDR_W | First-descriptor address |
| cfg_hwdesc_en | input | 1 | Hardware-descriptor mode enable |
| cfg_submit | input | 1 | Start pulse |
| cfg_cyclic | input | 1 | Legacy auto-repeat request |
| cyclic_active | output | 1 | Auto-repeat request after masking |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | ADDR_W | Descriptor address |
| m_arlen | output | 8 | Burst length minus one |
| m_arsize | output | 3 | Beat size code |
| m_arburst | output | 2 | Burst type (incrementing) |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | DATA_W | Read data beat |
| m_rresp | input | 2 | Read response |
| m_rlast | input | 1 | Last beat of burst |
| req_valid | output | 1 | Transfer request valid |
| req_ready | input | 1 | Transfer request accepted |
| req_id | output | 32 | Descriptor identifier |
| req_dst | output | 64 | Destination address |
| req_src | output | 64 | Source address |
| req_xlen | output | 32 | Row byte count minus one |
| req_ylen | output | 32 | Row count field (2D) |
| req_sstride | output | 32 | Source stride (2D) |
| req_dstride | output | 32 | Destination stride (2D) |
| done_in | input | 1 | Completion of the accepted request |
| irq | output | 1 | End-of-segment interrupt pulse |
| busy | output | 1 | Walk in progress |
| err | output | 1 | Sticky fetch-error indication |

## Verification
The bench walks three-descriptor chains under varied read-address latency, gaps in the read data and stalls on the request port. It sweeps all four flag combinations on a chained descriptor. A design that mis-slices a field, or reads beats in the wrong byte order, shows up as wrong request values, and a zero x length catches an off-by-one on the byte count. Completion pulses sent while a request is still pending, and submits sent while busy, expose a walker that jumps ahead or restarts. An error on a middle beat checks that no request leaks out and that a fresh start clears the error. Start attempts that lack the enable or the written address must leave the walker idle.

// File: rtl/sgw_pkg.sv
// Shared types and layout constants for the descriptor walker.
// Assumes a fixed 48-byte descriptor with little-endian fields.
package sgw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_ADDR,
        ST_FETCH_DATA,
        ST_ISSUE,
        ST_WAIT_DONE
    } sgw_state_e;

    localparam int DESC_BYTES  = 48;
    localparam int DESC_BITS   = DESC_BYTES * 8;

    // Byte offsets inside a descriptor (software builds this layout)
    localparam int OFF_FLAGS   = 0;
    localparam int OFF_ID      = 4;
    localparam int OFF_DST     = 8;
    localparam int OFF_SRC     = 16;
    localparam int OFF_NEXT    = 24;
    localparam int OFF_YLEN    = 32;
    localparam int OFF_XLEN    = 36;
    localparam int OFF_SSTRIDE = 40;
    localparam int OFF_DSTRIDE = 44;

    localparam int FLAG_LAST   = 0;
    localparam int FLAG_IRQ    = 1;

    typedef struct packed {
        logic [31:0] flags;
        logic [31:0] id;
        logic [63:0] dst;
        logic [63:0] src;
        logic [63:0] nxt;
        logic [31:0] ylen;
        logic [31:0] xlen;
        logic [31:0] sstride;
        logic [31:0] dstride;
    } sgw_desc_t;

endpackage

// File: rtl/sgw_beat_store.sv
// Beat store: captures the beats of one descriptor burst into per-beat
// slots and remembers whether any beat carried an error response.
// Assumes the controller clears it before each burst and writes at most
// BEATS beats per burst.
module sgw_beat_store #(
    parameter int DATA_W = 64,
    parameter int BEATS  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    we,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [1:0]              wresp,
    output logic [BEATS*DATA_W-1:0] flat,
    output logic                    resp_bad
);
    localparam int IDX_W = $clog2(BEATS + 1);

    logic [IDX_W-1:0] idx;

    // Beat index: restarts on clear, advances per captured beat
    always_ff @(posedge clk) begin
        if (!rst_n || clr) idx <= '0;
        else if (we)       idx <= idx + 1'b1;
    end

    // Sticky error flag for the current burst
    always_ff @(posedge clk) begin
        if (!rst_n || clr)              resp_bad <= 1'b0;
        else if (we && wresp != 2'b00)  resp_bad <= 1'b1;
    end

    for (genvar g = 0; g < BEATS; g++) begin : g_slot
        logic [DATA_W-1:0] slot;
        // Slot g: holds beat g of the burst
        always_ff @(posedge clk) begin
            if (!rst_n)                         slot <= '0;
            else if (we && idx == IDX_W'(g))    slot <= wdata;
        end
        assign flat[g*DATA_W +: DATA_W] = slot;
    end

    a_r3_beat_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> idx < IDX_W'(BEATS));

    a_r8_bad_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        resp_bad && !clr |=> resp_bad);

endmodule

// File: rtl/sgw_unpack.sv
// Field unpacker: slices the flat little-endian descriptor image into
// named fields. Pure combinational; assumes the image is DESC_BITS wide.
module sgw_unpack
    import sgw_pkg::*;
(
    input  logic [DESC_BITS-1:0] flat,
    output sgw_desc_t            desc
);
    // Field extraction at fixed byte offsets
    always_comb begin
        desc.flags   = flat[OFF_FLAGS*8   +: 32];
        desc.id      = flat[OFF_ID*8      +: 32];
        desc.dst     = flat[OFF_DST*8     +: 64];
        desc.src     = flat[OFF_SRC*8     +: 64];
        desc.nxt     = flat[OFF_NEXT*8    +: 64];
        desc.ylen    = flat[OFF_YLEN*8    +: 32];
        desc.xlen    = flat[OFF_XLEN*8    +: 32];
        desc.sstride = flat[OFF_SSTRIDE*8 +: 32];
        desc.dstride = flat[OFF_DSTRIDE*8 +: 32];
    end
endmodule

// File: rtl/sgw_ctrl.sv
// Walk controller: sequences start, descriptor fetch, request issue and
// completion wait, follows next pointers, raises interrupt pulses and the
// sticky error. Assumes one outstanding burst and one outstanding request.
module sgw_ctrl
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_addr_we,
    input  logic [ADDR_W-1:0] cfg_addr_wdata,
    input  logic              cfg_hwdesc_en,
    input  logic              cfg_submit,
    output logic              arvalid,
    input  logic              arready,
    output logic [ADDR_W-1:0] araddr,
    input  logic              rvalid,
    input  logic              rlast,
    input  logic [1:0]        rresp,
    output logic              rready,
    output logic              store_clr,
    output logic              beat_we,
    input  logic              resp_bad,
    input  logic [1:0]        desc_flags,
    input  logic [ADDR_W-1:0] desc_next,
    output logic              req_valid,
    input  logic              req_ready,
    input  logic              done_in,
    output logic              irq,
    output logic              busy,
    output logic              err
);
    sgw_state_e        state, state_nx;
    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] cur_addr;
    logic              addr_loaded;
    logic              start;
    logic              burst_end;
    logic              burst_bad;

    assign start     = (state == ST_IDLE) && cfg_submit && cfg_hwdesc_en && addr_loaded;
    assign burst_end = (state == ST_FETCH_DATA) && rvalid && rlast;
    assign burst_bad = resp_bad || (rresp != 2'b00);

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (start)   state_nx = ST_FETCH_ADDR;
            ST_FETCH_ADDR: if (arready) state_nx = ST_FETCH_DATA;
            ST_FETCH_DATA: if (burst_end)
                               state_nx = burst_bad ? ST_IDLE : ST_ISSUE;
            ST_ISSUE:      if (req_ready) state_nx = ST_WAIT_DONE;
            ST_WAIT_DONE:  if (done_in)
                               state_nx = desc_flags[FLAG_LAST] ? ST_IDLE : ST_FETCH_ADDR;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // First-descriptor address register and its written flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_addr  <= '0;
            addr_loaded <= 1'b0;
        end else if (cfg_addr_we) begin
            first_addr  <= cfg_addr_wdata;
            addr_loaded <= 1'b1;
        end
    end

    // Current descriptor pointer: seeded on start, chained on completion
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_addr <= '0;
        else if (start)
            cur_addr <= first_addr;
        else if (state == ST_WAIT_DONE && done_in && !desc_flags[FLAG_LAST])
            cur_addr <= desc_next;
    end

    // Interrupt pulse for a completed descriptor that asks for one
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (state == ST_WAIT_DONE) && done_in && desc_flags[FLAG_IRQ];
    end

    // Sticky fetch error: cleared by a new start, set on a bad burst
    always_ff @(posedge clk) begin
        if (!rst_n)                      err <= 1'b0;
        else if (start)                  err <= 1'b0;
        else if (burst_end && burst_bad) err <= 1'b1;
    end

    assign arvalid   = (state == ST_FETCH_ADDR);
    assign araddr    = cur_addr;
    assign rready    = (state == ST_FETCH_DATA);
    assign beat_we   = rready && rvalid;
    assign store_clr = (state == ST_FETCH_ADDR);
    assign req_valid = (state == ST_ISSUE);
    assign busy      = (state != ST_IDLE);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !arvalid && !rready && !req_valid);

    a_r2_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cfg_submit && cfg_hwdesc_en));

    a_r3_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid && !arready |=> arvalid && $stable(araddr));

    a_r6_last_idles: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WAIT_DONE && done_in && desc_flags[FLAG_LAST] |=> !busy);

    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r8_err_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    a_r11_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_WAIT_DONE |=> !irq);

endmodule

// File: rtl/sg_desc_walker.sv
// Top of the scatter-gather descriptor walker: joins the controller, the
// beat store and the field unpacker, drives the burst format and the
// request port. Assumes DATA_W divides the 384-bit descriptor image.
module sg_desc_walker
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_addr_we,
    input  logic [ADDR_W-1:0] cfg_addr_wdata,
    input  logic              cfg_hwdesc_en,
    input  logic              cfg_submit,
    input  logic              cfg_cyclic,
    output logic              cyclic_active,
    output logic              m_arvalid,
    input  logic              m_arready,
    output logic [ADDR_W-1:0] m_araddr,
    output logic [7:0]        m_arlen,
    output logic [2:0]        m_arsize,
    output logic [1:0]        m_arburst,
    input  logic              m_rvalid,
    output logic              m_rready,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic [1:0]        m_rresp,
    input  logic              m_rlast,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [31:0]       req_id,
    output logic [63:0]       req_dst,
    output logic [63:0]       req_src,
    output logic [31:0]       req_xlen,
    output logic [31:0]       req_ylen,
    output logic [31:0]       req_sstride,
    output logic [31:0]       req_dstride,
    input  logic              done_in,
    output logic              irq,
    output logic              busy,
    output logic              err
);
    localparam int BEATS    = DESC_BITS / DATA_W;
    localparam int SIZE_LOG = $clog2(DATA_W / 8);

    logic                 store_clr;
    logic                 beat_we;
    logic                 resp_bad;
    logic [DESC_BITS-1:0] flat;
    sgw_desc_t            desc;
    logic                 unused_flags;

    assign unused_flags = ^desc.flags[31:2];

    sgw_beat_store #(.DATA_W(DATA_W), .BEATS(BEATS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (store_clr),
        .we       (beat_we),
        .wdata    (m_rdata),
        .wresp    (m_rresp),
        .flat     (flat),
        .resp_bad (resp_bad)
    );

    sgw_unpack u_unpack (
        .flat (flat),
        .desc (desc)
    );

    sgw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_addr_we    (cfg_addr_we),
        .cfg_addr_wdata (cfg_addr_wdata),
        .cfg_hwdesc_en  (cfg_hwdesc_en),
        .cfg_submit     (cfg_submit),
        .arvalid        (m_arvalid),
        .arready        (m_arready),
        .araddr         (m_araddr),
        .rvalid         (m_rvalid),
        .rlast          (m_rlast),
        .rresp          (m_rresp),
        .rready         (m_rready),
        .store_clr      (store_clr),
        .beat_we        (beat_we),
        .resp_bad       (resp_bad),
        .desc_flags     (desc.flags[1:0]),
        .desc_next      (desc.nxt[ADDR_W-1:0]),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .done_in        (done_in),
        .irq            (irq),
        .busy           (busy),
        .err            (err)
    );

    // Fixed burst format: one incrementing burst covering the descriptor
    assign m_arlen   = 8'(BEATS - 1);
    assign m_arsize  = 3'(SIZE_LOG);
    assign m_arburst = 2'b01;

    // Request fields straight from the captured descriptor
    assign req_id      = desc.id;
    assign req_dst     = desc.dst;
    assign req_src     = desc.src;
    assign req_xlen    = desc.xlen;
    assign req_ylen    = desc.ylen;
    assign req_sstride = desc.sstride;
    assign req_dstride = desc.dstride;

    // Legacy auto-repeat masked in hardware-descriptor mode
    assign cyclic_active = cfg_cyclic && !cfg_hwdesc_en;

    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_dst) && $stable(req_src)
            && $stable(req_xlen) && $stable(req_ylen) && $stable(req_id)
            && $stable(req_sstride) && $stable(req_dstride));

    a_r8_no_bad_request: assert property (@(posedge clk) disable iff (!rst_n)
        m_rvalid && m_rready && m_rlast && (m_rresp != 2'b00) |=> !req_valid);

endmodule

// File: tb/tb_sg_desc_walker.sv
module tb_sg_desc_walker;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_addr_we = 1'b0;
    logic [63:0] cfg_addr_wdata = '0;
    logic        cfg_hwdesc_en = 1'b0;
    logic        cfg_submit = 1'b0;
    logic        cfg_cyclic = 1'b0;
    logic        cyclic_active;
    logic        m_arvalid;
    logic        m_arready = 1'b0;
    logic [63:0] m_araddr;
    logic [7:0]  m_arlen;
    logic [2:0]  m_arsize;
    logic [1:0]  m_arburst;
    logic        m_rvalid = 1'b0;
    logic        m_rready;
    logic [63:0] m_rdata = '0;
    logic [1:0]  m_rresp = '0;
    logic        m_rlast = 1'b0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_id, req_xlen, req_ylen, req_sstride, req_dstride;
    logic [63:0] req_dst, req_src;
    logic        done_in = 1'b0;
    logic        irq, busy, err;

    always #(CLK_PERIOD/2) clk = ~clk;

    sg_desc_walker dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr_we(cfg_addr_we), .cfg_addr_wdata(cfg_addr_wdata),
        .cfg_hwdesc_en(cfg_hwdesc_en), .cfg_submit(cfg_submit),
        .cfg_cyclic(cfg_cyclic), .cyclic_active(cyclic_active),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
        .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata),
        .m_rresp(m_rresp), .m_rlast(m_rlast),
        .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
        .req_dst(req_dst), .req_src(req_src), .req_xlen(req_xlen),
        .req_ylen(req_ylen), .req_sstride(req_sstride), .req_dstride(req_dstride),
        .done_in(done_in), .irq(irq), .busy(busy), .err(err)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [7:0]  mem [0:1023];
    logic [63:0] s_addr [8];
    logic [31:0] s_flags [8];
    logic [31:0] s_id [8];
    logic [63:0] s_dst [8];
    logic [63:0] s_src [8];
    logic [63:0] s_next [8];
    logic [31:0] s_ylen [8];
    logic [31:0] s_xlen [8];
    logic [31:0] s_ss [8];
    logic [31:0] s_ds [8];

    int          ar_lat = 0;
    bit          r_gap = 1'b0;
    int          ar_count = 0;
    logic [63:0] last_ar_addr = '0;
    logic [63:0] err_addr = '1;
    int          err_beat = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [63:0] a, input int n, input logic [63:0] v);
        for (int i = 0; i < n; i++) mem[(a + 64'(i)) & 64'd1023] = v[8*i +: 8];
    endtask

    function automatic logic [63:0] beat_of(input logic [63:0] a, input int b);
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[8*i +: 8] = mem[(a + 64'(8*b + i)) & 64'd1023];
        return v;
    endfunction

    // Build descriptor slot k at address a; fields derived from seed
    task automatic set_desc(input int k, input logic [63:0] a, input logic [31:0] fl,
                            input logic [63:0] nxt, input int seed);
        s_addr[k]  = a;
        s_flags[k] = fl;
        s_id[k]    = 32'h5EED_0000 + 32'(seed) * 32'h11;
        s_dst[k]   = 64'hD000_0000_0000_0000 + 64'(seed) * 64'h1_0000_0100;
        s_src[k]   = 64'h0000_5000_0000_0000 + 64'(seed) * 64'h40;
        s_next[k]  = nxt;
        s_ylen[k]  = 32'(seed % 3);
        s_xlen[k]  = 32'(seed) * 32'h0101_0007;
        s_ss[k]    = 32'(seed) * 32'd16;
        s_ds[k]    = 32'(seed) * 32'd24;
        put(a + 0,  4, 64'(s_flags[k]));
        put(a + 4,  4, 64'(s_id[k]));
        put(a + 8,  8, s_dst[k]);
        put(a + 16, 8, s_src[k]);
        put(a + 24, 8, s_next[k]);
        put(a + 32, 4, 64'(s_ylen[k]));
        put(a + 36, 4, 64'(s_xlen[k]));
        put(a + 40, 4, 64'(s_ss[k]));
        put(a + 44, 4, 64'(s_ds[k]));
    endtask

    // Memory responder for descriptor reads
    initial begin
        logic [63:0] a;
        forever begin
            @(negedge clk);
            if (m_arvalid) begin
                a = m_araddr;
                repeat (ar_lat) @(negedge clk);
                check(m_arvalid && m_araddr == a, "R3 address held until ready", m_araddr, a);
                check(m_arlen == 8'd5, "R3 arlen", 64'(m_arlen), 64'd5);
                check(m_arsize == 3'd3 && m_arburst == 2'b01, "R3 arsize/arburst",
                      64'({m_arsize, m_arburst}), 64'({3'd3, 2'b01}));
                last_ar_addr = a;
                ar_count++;
                m_arready = 1'b1;
                @(negedge clk);
                m_arready = 1'b0;
                for (int b = 0; b < 6; b++) begin
                    if (r_gap && b == 2) @(negedge clk);
                    m_rvalid = 1'b1;
                    m_rdata  = beat_of(a, b);
                    m_rresp  = (a == err_addr && b == err_beat) ? 2'b10 : 2'b00;
                    m_rlast  = (b == 5);
                    @(negedge clk);
                    m_rvalid = 1'b0;
                    m_rlast  = 1'b0;
                    m_rresp  = 2'b00;
                end
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog: a hung run is a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL R6 watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            summary();
            $finish;
        end
    end

    task automatic start_walk(input logic [63:0] a);
        @(negedge clk);
        cfg_addr_we = 1'b1; cfg_addr_wdata = a;
        @(negedge clk);
        cfg_addr_we = 1'b0; cfg_submit = 1'b1;
        @(negedge clk);
        cfg_submit = 1'b0;
        check(busy == 1'b1, "R9 busy after start", 64'(busy), 64'd1);
        check(err == 1'b0, "R8 err cleared by start", 64'(err), 64'd0);
    endtask

    // Walk a chain from address a and check every request and completion
    task automatic run_chain(input logic [63:0] a, input int rdy_delay,
                             input bit poke_done, input bit poke_submit);
        logic [63:0] cur;
        int k;
        start_walk(a);
        cur = a;
        for (int step = 0; step < 8; step++) begin
            int n = 0;
            k = 0;
            for (int j = 0; j < 8; j++) if (s_addr[j] == cur) k = j;
            while (!req_valid && n < 300) begin @(negedge clk); n++; end
            check(req_valid, "R6 request issued", 64'(req_valid), 64'd1);
            check(last_ar_addr == cur, "R6 fetch address follows chain", last_ar_addr, cur);
            check(req_id == s_id[k], "R4 id", 64'(req_id), 64'(s_id[k]));
            check(req_dst == s_dst[k], "R4 dst", req_dst, s_dst[k]);
            check(req_src == s_src[k], "R4 src", req_src, s_src[k]);
            check(req_xlen == s_xlen[k], "R4 xlen", 64'(req_xlen), 64'(s_xlen[k]));
            check(req_ylen == s_ylen[k], "R4 ylen", 64'(req_ylen), 64'(s_ylen[k]));
            check(req_sstride == s_ss[k] && req_dstride == s_ds[k], "R4 strides",
                  {req_sstride, req_dstride}, {s_ss[k], s_ds[k]});
            for (int d = 0; d < rdy_delay; d++) begin
                if (poke_done && d == 0) done_in = 1'b1;
                @(negedge clk);
                done_in = 1'b0;
                check(req_valid && req_dst == s_dst[k] && req_xlen == s_xlen[k],
                      "R5 request held while stalled", 64'(req_valid), 64'd1);
                if (poke_done && d == 0)
                    check(irq == 1'b0, "R11 early done ignored", 64'(irq), 64'd0);
            end
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            check(req_valid == 1'b0, "R5 request dropped after accept", 64'(req_valid), 64'd0);
            if (poke_submit) cfg_submit = 1'b1;
            @(negedge clk);
            cfg_submit = 1'b0;
            check(irq == 1'b0, "R7 no irq before done", 64'(irq), 64'd0);
            done_in = 1'b1;
            @(negedge clk);
            done_in = 1'b0;
            check(irq == s_flags[k][1], "R7 irq on completion", 64'(irq), 64'(s_flags[k][1]));
            check(busy == !s_flags[k][0], "R6 busy after completion", 64'(busy),
                  64'(!s_flags[k][0]));
            @(negedge clk);
            check(irq == 1'b0, "R7 irq one cycle", 64'(irq), 64'd0);
            if (s_flags[k][0]) break;
            cur = s_next[k];
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        for (int j = 0; j < 8; j++) s_addr[j] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !err && !irq, "R1 reset status", 64'({busy, err, irq}), 64'd0);
        check(!req_valid && !m_arvalid && !m_rready, "R1 reset handshakes",
              64'({req_valid, m_arvalid, m_rready}), 64'd0);

        // R2: submit with no address written
        cfg_hwdesc_en = 1'b1;
        cfg_submit = 1'b1;
        @(negedge clk);
        cfg_submit = 1'b0;
        repeat (4) @(negedge clk);
        check(!busy && ar_count == 0, "R2 submit without address ignored", 64'(busy), 64'd0);

        // R2: address written but mode disabled
        cfg_hwdesc_en = 1'b0;
        cfg_addr_we = 1'b1; cfg_addr_wdata = 64'h40;
        @(negedge clk);
        cfg_addr_we = 1'b0; cfg_submit = 1'b1;
        @(negedge clk);
        cfg_submit = 1'b0;
        repeat (4) @(negedge clk);
        check(!busy && ar_count == 0, "R2 submit without enable ignored", 64'(busy), 64'd0);

        // R10: all enable/cyclic combinations
        for (int c = 0; c < 4; c++) begin
            cfg_cyclic = c[0]; cfg_hwdesc_en = c[1];
            @(negedge clk);
            check(cyclic_active == (c[0] && !c[1]), "R10 cyclic masking",
                  64'(cyclic_active), 64'(c[0] && !c[1]));
        end
        cfg_cyclic = 1'b0;
        cfg_hwdesc_en = 1'b1;

        // Three-descriptor chain, stalls and stray done/submit pulses
        set_desc(0, 64'h040, 32'h2, 64'h100, 0);
        set_desc(1, 64'h100, 32'h0, 64'h180, 5);
        set_desc(2, 64'h180, 32'h3, 64'h3C0, 9);
        ar_lat = 1; r_gap = 1'b0;
        run_chain(64'h040, 2, 1'b1, 1'b1);
        check(ar_count == 3, "R9 submit while busy no restart", 64'(ar_count), 64'd3);

        // Same chain, no latency, gapped read data, no stalls
        ar_lat = 0; r_gap = 1'b1;
        run_chain(64'h040, 0, 1'b0, 1'b0);
        check(ar_count == 6, "R6 chain fetch count", 64'(ar_count), 64'd6);

        // Sweep flag combinations on a chained head descriptor
        for (int f = 0; f < 4; f++) begin
            set_desc(3, 64'h200, 32'(f), 64'h240, 10 + f);
            set_desc(4, 64'h240, 32'h1, 64'h000, 20 + f);
            ar_lat = f; r_gap = f[0];
            run_chain(64'h200, f, 1'b0, 1'b0);
        end

        // R8: error response on a middle beat
        set_desc(5, 64'h300, 32'h3, 64'h000, 30);
        err_addr = 64'h300; err_beat = 2;
        begin
            int n = 0;
            bit saw_req = 1'b0;
            start_walk(64'h300);
            while (busy && n < 100) begin
                @(negedge clk);
                if (req_valid) saw_req = 1'b1;
                n++;
            end
            check(!saw_req, "R8 no request after error", 64'(saw_req), 64'd0);
            check(!busy && err, "R8 idle with err set", 64'({busy, err}), 64'b01);
        end
        err_addr = '1;
        repeat (3) @(negedge clk);
        check(err == 1'b1, "R8 err sticky while idle", 64'(err), 64'd1);

        // Fresh start clears err; single last descriptor without irq
        run_chain(64'h240, 1, 1'b0, 1'b0);

        // R11: done while idle is ignored
        done_in = 1'b1;
        @(negedge clk);
        done_in = 1'b0;
        check(irq == 1'b0 && !busy, "R11 idle done ignored", 64'(irq), 64'd0);

        summary();
        $finish;
    end
endmodule